// File: doc/BRIEF.md
# Indirect PHY Delay Register Access Port

This block lets host software reach a bank of 8-bit PHY delay settings through a single 32-bit control word, without mapping the PHY registers into the host address space. Software loads an address and a data byte into the control word, then raises either a write request bit or a read request bit. The block latches the request, waits a programmable number of clock cycles to model the PHY-side access time, performs the access, and raises an acknowledge bit. For reads, it places the fetched byte in a read-back field.

Software polls the acknowledge bit and then lowers its request bit. The block drops the acknowledge one clock after it sees both request bits low, which completes a four-phase handshake. The PHY bank has 64 address slots. Only twelve of them hold storage: the input-delay and DLL-delay slots at 0x00 to 0x08 and 0x0B to 0x0D. The remaining slots read as zero and ignore writes.

Top module: `phy_access_port`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x0000_0000 and every PHY slot reads 0x00.
- R2: Control word layout. Bit 26 is acknowledge, bit 25 is read request and bit 24 is write request. Bits 23:16 are read-back data, bits 15:8 are write data and bits 5:0 are the PHY address. Host writes update bits 25, 24, 15:8 and 5:0, and these read back as written. Bits 31:27 and 7:6 always read 0. Host writes never change bits 26 or 23:16.
- R3: When a host write sets a request bit while acknowledge is low, the access is performed. Acknowledge first reads 1 exactly LATENCY+1 clock edges after the edge that loaded the request. It reads 0 one edge earlier.
- R4: Acknowledge stays 1 for as long as either request bit remains set.
- R5: Once the control word shows both request bits low, acknowledge reads 0 after exactly one further clock edge.
- R6: The read-back field takes the addressed slot's value when a read access completes. It holds its value at all other times, including across write accesses.
- R7: If both request bits are set together, the access is a write. The read-back field is left unchanged.
- R8: The address and data are latched when an access starts. Changing them in the control word while the access is in flight does not affect that access. A new access starts only after acknowledge has returned low.
- R9: Slots 0x00 to 0x08 and 0x0B to 0x0D store written bytes. All other slots read 0x00, ignore writes, and still complete the handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write enable for the control word |
| host_wdata | input | 32 | Host write value for the control word |
| host_rdata | output | 32 | Current control word as seen by the host |

## Verification
The in-RTL assertions check the following on every cycle:
- acknowledge holding while a request bit is set;
- acknowledge releasing one cycle after both requests are low;
- acknowledge rising only after a completed access;
- a new access starting only from a low acknowledge;
- read-back data staying stable except on a read completion;
- a finished write being visible at the addressed slot.

Other behaviours can only be shown by the bench scenarios:
- the exact LATENCY+1 acknowledge timing;
- the field layout and its read-only bits;
- which slots exist;
- write-wins priority when both request bits are set;
- immunity of an in-flight access to rewritten address and data.

// File: rtl/phy_port_pkg.sv
// Package: shared field positions, widths, state type and slot map for the
// indirect PHY access port. Assumes a fixed 32-bit host control word.
package phy_port_pkg;

    localparam int ACK_BIT   = 26;
    localparam int RREQ_BIT  = 25;
    localparam int WREQ_BIT  = 24;
    localparam int RBACK_LSB = 16;
    localparam int WBYTE_LSB = 8;
    localparam int SLOT_LSB  = 0;

    localparam int SLOT_W = 6;
    localparam int BYTE_W = 8;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WAIT = 2'd1,
        XS_DONE = 2'd2
    } xfer_state_t;

    // True for slots that carry real delay storage.
    function automatic logic slot_present(input int unsigned idx);
        return (idx <= 8) || ((idx >= 11) && (idx <= 13));
    endfunction

endpackage

// File: rtl/phy_port_ctrlword.sv
// Module: host-visible control word. Holds the software-writable fields and
// the read-back byte, and assembles the 32-bit view. Assumes the handshake
// engine supplies the acknowledge level and a one-cycle read-complete pulse.
module phy_port_ctrlword
    import phy_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    input  logic              ack,
    input  logic              rd_fire,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              wreq,
    output logic              rreq,
    output logic [SLOT_W-1:0] slot,
    output logic [BYTE_W-1:0] wbyte,
    output logic [31:0]       word
);

    logic [BYTE_W-1:0] rback_q;
    logic              unused_bits;

    assign unused_bits = ^{host_wdata[31:27], host_wdata[ACK_BIT],
                           host_wdata[RBACK_LSB +: BYTE_W], host_wdata[7:6]};

    // Capture software fields on host writes and read-back byte on read completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wreq    <= 1'b0;
            rreq    <= 1'b0;
            slot    <= '0;
            wbyte   <= '0;
            rback_q <= '0;
        end else begin
            if (host_we) begin
                wreq  <= host_wdata[WREQ_BIT];
                rreq  <= host_wdata[RREQ_BIT];
                slot  <= host_wdata[SLOT_LSB +: SLOT_W];
                wbyte <= host_wdata[WBYTE_LSB +: BYTE_W];
            end
            if (rd_fire) begin
                rback_q <= rd_byte;
            end
        end
    end

    // Assemble the 32-bit host view; unassigned bits read zero.
    always_comb begin
        word = '0;
        word[ACK_BIT]                = ack;
        word[RREQ_BIT]               = rreq;
        word[WREQ_BIT]               = wreq;
        word[RBACK_LSB +: BYTE_W]    = rback_q;
        word[WBYTE_LSB +: BYTE_W]    = wbyte;
        word[SLOT_LSB +: SLOT_W]     = slot;
    end

    a_r6_rback_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(word[RBACK_LSB +: BYTE_W]));

endmodule

// File: rtl/phy_port_handshake.sv
// Module: request/acknowledge engine. Latches slot and byte when a request
// appears with acknowledge low, waits LATENCY cycles, fires one access pulse,
// then holds acknowledge until both request bits drop. Write wins over read.
// Assumes LATENCY >= 1.
module phy_port_handshake
    import phy_port_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wreq,
    input  logic              rreq,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              ack,
    output logic              wr_fire,
    output logic              rd_fire,
    output logic [SLOT_W-1:0] acc_slot,
    output logic [BYTE_W-1:0] acc_byte
);

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    xfer_state_t      state;
    logic [CNT_W-1:0] cnt;
    logic             acc_is_wr;
    logic             fire;

    // Sequence one access: idle -> wait LATENCY cycles -> acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= XS_IDLE;
            cnt       <= '0;
            acc_slot  <= '0;
            acc_byte  <= '0;
            acc_is_wr <= 1'b0;
        end else begin
            case (state)
                XS_IDLE: begin
                    if (wreq || rreq) begin
                        state     <= XS_WAIT;
                        cnt       <= CNT_W'(LATENCY - 1);
                        acc_slot  <= slot;
                        acc_byte  <= wbyte;
                        acc_is_wr <= wreq;
                    end
                end
                XS_WAIT: begin
                    if (cnt == '0) begin
                        state <= XS_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_DONE: begin
                    if (!wreq && !rreq) begin
                        state <= XS_IDLE;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    // Decode the access pulse on the last waiting cycle and the acknowledge level.
    always_comb begin
        fire    = (state == XS_WAIT) && (cnt == '0);
        wr_fire = fire && acc_is_wr;
        rd_fire = fire && !acc_is_wr;
        ack     = (state == XS_DONE);
    end

    a_r4_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (wreq || rreq)) |=> ack);

    a_r5_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wreq && !rreq) |=> !ack);

    a_r3_ack_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire || rd_fire) |=> ack);

    a_r8_start_from_low_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == XS_WAIT) && ($past(state) != XS_WAIT)) |-> !$past(ack));

endmodule

// File: rtl/phy_delay_bank.sv
// Module: PHY-side delay byte bank. Only slots flagged by slot_present()
// carry flops; the others read zero and discard writes. Single write port
// and one combinational read port. Assumes NUM_SLOTS <= 64.
module phy_delay_bank
    import phy_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [SLOT_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] slot_bus [NUM_SLOTS];

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
        if (slot_present(gi)) begin : g_store
            logic [BYTE_W-1:0] q;
            // Hold one delay byte; load it on a write aimed at this slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (waddr == SLOT_W'(gi))) begin
                    q <= wdata;
                end
            end
            assign slot_bus[gi] = q;
        end else begin : g_hole
            assign slot_bus[gi] = '0;
        end
    end

    // Select the addressed slot for read.
    always_comb begin
        rdata = slot_bus[raddr];
    end

    a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((raddr != $past(waddr)) ||
                (rdata == (slot_present(32'($past(waddr))) ? $past(wdata) : '0))));

endmodule

// File: rtl/phy_access_port.sv
// Module: top of the indirect PHY access port. Joins the host control word,
// the handshake engine and the delay bank. LATENCY sets the PHY-side access
// time in clock cycles (>= 1).
module phy_access_port
    import phy_port_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);

    logic              wreq, rreq, ack, wr_fire, rd_fire;
    logic [SLOT_W-1:0] slot, acc_slot;
    logic [BYTE_W-1:0] wbyte, acc_byte, bank_rdata;

    phy_port_ctrlword u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .ack        (ack),
        .rd_fire    (rd_fire),
        .rd_byte    (bank_rdata),
        .wreq       (wreq),
        .rreq       (rreq),
        .slot       (slot),
        .wbyte      (wbyte),
        .word       (host_rdata)
    );

    phy_port_handshake #(.LATENCY(LATENCY)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wreq     (wreq),
        .rreq     (rreq),
        .slot     (slot),
        .wbyte    (wbyte),
        .ack      (ack),
        .wr_fire  (wr_fire),
        .rd_fire  (rd_fire),
        .acc_slot (acc_slot),
        .acc_byte (acc_byte)
    );

    phy_delay_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire),
        .waddr (acc_slot),
        .wdata (acc_byte),
        .raddr (acc_slot),
        .rdata (bank_rdata)
    );

    a_r7_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && rd_fire));

endmodule

// File: tb/sim_phy_access_port.sv
// Bench: sweeps every slot with writes and reads, checks handshake timing
// cycle by cycle, and covers layout, priority and in-flight change cases.
module sim_phy_access_port;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] model [64];

    phy_access_port #(.LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit has_slot(input int a);
        return (a <= 8) || (a >= 11 && a <= 13);
    endfunction

    function automatic logic [31:0] pack(input logic [5:0] a, input logic [7:0] d,
                                         input bit w, input bit r);
        return {5'b0, 1'b0, r, w, 8'h00, d, 2'b00, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic poll_ack();
        for (int i = 0; i < 200; i++) begin
            if (host_rdata[26]) break;
            @(negedge clk);
        end
    endtask

    // One full handshake; timed=1 checks the exact acknowledge edge.
    task automatic access(input logic [5:0] a, input logic [7:0] d, input bit w,
                          input bit r, input bit timed, output logic [7:0] rb);
        hw(pack(a, d, w, r));
        if (timed) begin
            repeat (LAT) @(negedge clk);
            chk(host_rdata[26] == 1'b0, "R3 ack early", {31'b0, host_rdata[26]}, 0);
            @(negedge clk);
            chk(host_rdata[26] == 1'b1, "R3 ack at LATENCY+1", {31'b0, host_rdata[26]}, 1);
            repeat (3) @(negedge clk);
            chk(host_rdata[26] == 1'b1, "R4 ack held", {31'b0, host_rdata[26]}, 1);
        end else begin
            poll_ack();
            chk(host_rdata[26] == 1'b1, "R3 ack seen", {31'b0, host_rdata[26]}, 1);
        end
        rb = host_rdata[23:16];
        hw(pack(a, d, 1'b0, 1'b0));
        chk(host_rdata[26] == 1'b1, "R5 ack before release edge", {31'b0, host_rdata[26]}, 1);
        @(negedge clk);
        chk(host_rdata[26] == 1'b0, "R5 ack released", {31'b0, host_rdata[26]}, 0);
    endtask

    initial begin
        logic [7:0] rb;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_rdata == 32'h0, "R1 reset word", host_rdata, 32'h0);

        // R1: reset contents of stored slots
        access(6'h00, 8'h00, 1'b0, 1'b1, 1'b1, rb);
        chk(rb == 8'h00, "R1 slot 0x00 reset", {24'b0, rb}, 0);
        access(6'h0D, 8'h00, 1'b0, 1'b1, 1'b1, rb);
        chk(rb == 8'h00, "R1 slot 0x0D reset", {24'b0, rb}, 0);

        // R2 layout with all ones written; also R7 both requests at an empty slot
        hw(32'hFFFF_FFFF);
        chk(host_rdata == 32'h0300_FF3F, "R2 field readback", host_rdata, 32'h0300_FF3F);
        poll_ack();
        chk(host_rdata[23:16] == 8'h00, "R7 rback unchanged", {24'b0, host_rdata[23:16]}, 0);
        chk(host_rdata[31:27] == 5'b0 && host_rdata[7:6] == 2'b0, "R2 zero bits",
            host_rdata, 32'h0);
        hw(pack(6'h3F, 8'hFF, 1'b0, 1'b0));
        @(negedge clk);
        chk(host_rdata[26] == 1'b0, "R5 after both-request access", {31'b0, host_rdata[26]}, 0);

        // R3/R9: write sweep over every slot
        for (int a = 0; a < 64; a++) begin
            logic [7:0] d;
            d = 8'((a * 37 + 5) & 255);
            model[a] = has_slot(a) ? d : 8'h00;
            access(6'(a), d, 1'b1, 1'b0, 1'b1, rb);
        end
        // R6/R9: read sweep over every slot
        for (int a = 0; a < 64; a++) begin
            access(6'(a), 8'h00, 1'b0, 1'b1, 1'b1, rb);
            chk(rb == model[a], "R9 slot readback", {24'b0, rb}, {24'b0, model[a]});
        end

        // R6: read-back held across a write access
        access(6'h0C, 8'h00, 1'b0, 1'b1, 1'b0, rb);
        keep = model[12];
        chk(rb == keep, "R6 read slot 0x0C", {24'b0, rb}, {24'b0, keep});
        access(6'h05, 8'h5A, 1'b1, 1'b0, 1'b0, rb);
        model[5] = 8'h5A;
        chk(rb == keep, "R6 hold across write", {24'b0, rb}, {24'b0, keep});
        chk(host_rdata[2] == 1'b1, "R2 slot field", host_rdata, 32'h5);

        // R7: both requests at a stored slot is a write
        access(6'h03, 8'hC3, 1'b1, 1'b1, 1'b0, rb);
        chk(rb == keep, "R7 no read on both", {24'b0, rb}, {24'b0, keep});
        model[3] = 8'hC3;
        access(6'h03, 8'h00, 1'b0, 1'b1, 1'b0, rb);
        chk(rb == 8'hC3, "R7 write landed", {24'b0, rb}, 32'hC3);

        // R8: change slot/byte while access in flight
        hw(pack(6'h01, 8'h11, 1'b1, 1'b0));
        hw(pack(6'h02, 8'h22, 1'b1, 1'b0));
        poll_ack();
        chk(host_rdata[5:0] == 6'h02, "R8 word shows new slot", {26'b0, host_rdata[5:0]}, 2);
        hw(pack(6'h02, 8'h22, 1'b0, 1'b0));
        @(negedge clk);
        model[1] = 8'h11;
        access(6'h01, 8'h00, 1'b0, 1'b1, 1'b0, rb);
        chk(rb == 8'h11, "R8 latched slot written", {24'b0, rb}, 32'h11);
        access(6'h02, 8'h00, 1'b0, 1'b1, 1'b0, rb);
        chk(rb == model[2], "R8 new slot untouched", {24'b0, rb}, {24'b0, model[2]});

        // R9: empty slot ignores a write and still handshakes
        access(6'h0A, 8'hEE, 1'b1, 1'b0, 1'b1, rb);
        access(6'h0A, 8'h00, 1'b0, 1'b1, 1'b1, rb);
        chk(rb == 8'h00, "R9 empty slot reads zero", {24'b0, rb}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule